// File: doc/BRIEF.md
# Redundant-Digit to Two's-Complement Converter

This block turns a vector of signed-binary digits into an ordinary two's-complement number one bit wider than the digit count. Each digit takes one of the values −1, 0 or +1. It arrives on two parallel buses, one holding a sign flag per digit and the other a magnitude flag per digit. A negate control flips every digit sign before conversion, so the same hardware returns either the value or its negation. Typical users are datapaths that keep sums and differences in redundant form to avoid carry chains, such as a ±1 complex multiplier that needs ±(a+b) and ±(a−b). For those users this block is the one place where a carry has to ripple.

The conversion uses a single parallel-prefix carry network with no carry-in. Each digit drives the network through a mux-style cell. A nonzero magnitude makes the digit kill or generate a carry, depending on its sign. A zero magnitude makes the digit pass the carry through, and the sign is ignored. The low result bits are the magnitudes XORed with the incoming carries. The top result bit is the carry out of the whole network, so no separate sign extension is needed. The result is registered, with a valid flag alongside.

Top module: `sbnr_to_twos`

## Requirements
- R1: With `negate` low, digit i has weight 2^i. Its code is (sign,mag): (0,0) means 0, (0,1) means +1 and (1,1) means −1. `out_value` is the (WIDTH+1)-bit two's-complement encoding of the sum of the weighted digits.
- R2: With `negate` high, `out_value` is the (WIDTH+1)-bit two's-complement encoding of the negated sum.
- R3: The top bit of `out_value` is correct over the whole range −(2^WIDTH−1) to +(2^WIDTH−1). In particular, it is 0 whenever no digit is negative after the negate control is applied.
- R4: The code (sign,mag) = (1,0) counts as a zero digit, with `negate` low or high.
- R5: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. The matching result is on `out_value` in that same cycle.
- R6: While `out_valid` is low, `out_value` keeps the last result it showed.
- R7: While `rst_n` is low, `out_valid` and `out_value` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Digit vector on the inputs is to be converted |
| in_sign | input | WIDTH | Sign flag of each digit |
| in_mag | input | WIDTH | Magnitude flag of each digit |
| negate | input | 1 | Flip all digit signs before conversion |
| out_valid | output | 1 | Result present on out_value |
| out_value | output | WIDTH+1 | Two's-complement result |

## Verification
Every converted vector is due exactly one clock after the cycle that presented it, because a single output register sits between the inputs and `out_value`. The driver changes the inputs on the falling edge and records the expected word in a queue. The monitor samples on later falling edges, and it pops the queue only when `out_valid` is high. Any valid pulse with nothing expected is therefore a latency failure, and so is any entry left in the queue at the end. Hold behaviour is sampled on the idle falling edges that come after the result cycle. Every one of the 3^8 legal digit vectors is converted with both settings of `negate`, and a stream of vectors containing the unused code follows.

// File: rtl/sbnr_to_twos.sv
module sbnr_to_twos #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_sign,
  input  logic [WIDTH-1:0] in_mag,
  input  logic             negate,
  output logic             out_valid,
  output logic [WIDTH:0]   out_value
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;

  logic [WIDTH-1:0] eff_sign;
  logic [WIDTH-1:0] pass;
  logic [WIDTH-1:0] carry_in;
  logic             carry_top;
  logic [WIDTH:0]   result;

  assign eff_sign = in_sign ^ {WIDTH{negate}};
  assign pass     = ~in_mag;

  // Prefix cell: pass takes the lower group's carry, otherwise the sign decides.
  for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
    logic [WIDTH-1:0] gg;
    logic [WIDTH-1:0] pp;
    if (k == 0) begin : g_leaf
      assign gg = eff_sign;
      assign pp = pass;
    end else begin : g_node
      localparam int DIST = 1 << (k - 1);
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= DIST) begin : g_comb
          assign gg[i] = g_lvl[k-1].pp[i] ? g_lvl[k-1].gg[i-DIST] : g_lvl[k-1].gg[i];
          assign pp[i] = g_lvl[k-1].pp[i] & g_lvl[k-1].pp[i-DIST];
        end else begin : g_thru
          assign gg[i] = g_lvl[k-1].gg[i];
          assign pp[i] = g_lvl[k-1].pp[i];
        end
      end
    end
  end

  logic [WIDTH-1:0] carry_out;
  assign carry_out = ~g_lvl[LEVELS].pp & g_lvl[LEVELS].gg;

  if (WIDTH > 1) begin : g_cin
    assign carry_in = {carry_out[WIDTH-2:0], 1'b0};
  end else begin : g_cin1
    assign carry_in = 1'b0;
  end
  assign carry_top = carry_out[WIDTH-1];

  assign result = {carry_top, in_mag ^ carry_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_value <= result;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_value)); // R6
  AST_ZERO_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mag == '0) |=> out_value == '0); // R4
  AST_NONNEG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (eff_sign & in_mag) == '0) |=> !out_value[WIDTH]); // R3

endmodule

// File: tb/test_sbnr_to_twos.sv
module test_sbnr_to_twos;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [N-1:0] in_sign;
  logic [N-1:0] in_mag;
  logic         negate;
  logic         out_valid;
  logic [N:0]   out_value;

  logic [N:0] exp_q[$];
  string      tag_q[$];
  logic [N:0] last_exp;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sbnr_to_twos #(.WIDTH(N)) i_sbnr_to_twos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_mag(in_mag), .negate(negate), .out_valid(out_valid), .out_value(out_value)
  );

  task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N:0] ref_value(input logic [N-1:0] s, input logic [N-1:0] m, input logic neg);
    logic signed [31:0] v = 0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) v = ((s[i] ^ neg) != 1'b0) ? v - (32'sd1 <<< i) : v + (32'sd1 <<< i);
    end
    return v[N:0];
  endfunction

  task automatic drive(input logic [N-1:0] s, input logic [N-1:0] m, input logic neg, input string tag);
    logic [N:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_sign  = s;
    in_mag   = m;
    negate   = neg;
    e = ref_value(s, m, neg);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
  endtask

  task automatic idle_hold(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_sign  = '1;
    in_mag   = '1;
    repeat (n) begin
      @(negedge clk);
      #1;
      check("R6", out_value, last_exp);
      check("R5", {{N{1'b0}}, out_valid}, '0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL R5: actual out_valid 1 expected 0 (nothing pending)");
      end else begin
        check(tag_q.pop_front(), out_value, exp_q.pop_front());
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sign = '0; in_mag = '0; negate = 1'b0;
    last_exp = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_mag = '1;
    @(negedge clk);
    #1;
    check("R7", out_value, '0);
    check("R7", {{N{1'b0}}, out_valid}, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    drive(8'h00, 8'h01, 1'b0, "R1");
    drive(8'h00, 8'hFF, 1'b0, "R3");
    drive(8'hFF, 8'hFF, 1'b0, "R3");
    drive(8'h00, 8'hFF, 1'b1, "R3");
    drive(8'h80, 8'h80, 1'b0, "R3");
    drive(8'h7F, 8'hFF, 1'b0, "R3");
    drive(8'hFF, 8'h00, 1'b0, "R4");
    drive(8'hFF, 8'h00, 1'b1, "R4");
    idle_hold(3);

    for (int code = 0; code < 6561; code++) begin
      logic [N-1:0] s;
      logic [N-1:0] m;
      int r;
      r = code;
      for (int d = 0; d < N; d++) begin
        m[d] = (r % 3) != 0;
        s[d] = (r % 3) == 2;
        r = r / 3;
      end
      drive(s, m, 1'b0, "R1");
      drive(s, m, 1'b1, "R2");
    end
    idle_hold(2);

    for (int i = 0; i < 256; i++) begin
      logic [N-1:0] s;
      logic [N-1:0] m;
      s = N'(i * 73 + 5);
      m = N'(i * 151 + 29) & ~N'(i * 11);
      drive(s, m, 1'(i), "R4");
    end
    idle_hold(4);

    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5: actual %0d pending results expected 0", exp_q.size());
    end
    summary();
  end
endmodule